// File: doc/BRIEF.md
# UART interrupt status and trigger logic

This block produces every interrupt source of a UART and turns them into a raw status vector, a masked status vector and one combined interrupt line. Transmit and receive sources follow the fill levels of the two FIFOs against a programmable fraction of the FIFO depth. In single-register mode they follow whether the one holding location is empty or full instead. A receive timeout counts bit periods while the receive FIFO holds data that nobody touches. Framing, parity, break and overrun pulses are latched until software clears them. An end-of-transmission source shows when the transmit FIFO and the shifter are both idle.

The FIFOs, the framers and the register decoding sit outside. They supply the occupancy counts, the event pulses, a bit-period tick, the mask and a write-one-to-clear strobe. All status outputs are registered. Every output reflects the inputs sampled at the previous rising clock edge.

Status bit positions: 0 receive level, 1 transmit level, 2 receive timeout, 3 framing, 4 parity, 5 break, 6 overrun, 7 end of transmission.

Top module: `uart_irq_ctrl`

## Requirements
- R1: `mask_stat` equals `raw_stat` ANDed with the mask sampled at the same edge, and `irq` is 1 exactly when any bit of `mask_stat` is 1.
- R2: Level select code 1 picks DEPTH/4, code 2 picks DEPTH/2 and code 3 picks 3*DEPTH/4. Every other code (0, 4 to 7) picks DEPTH/2.
- R3: With `fifo_en`=1, raw bit 1 is 1 while `tx_count` is at or below the transmit level, and 0 once the count exceeds it.
- R4: With `fifo_en`=1, raw bit 0 is 1 while `rx_count` is at or above the receive level, and 0 once the count drops below it.
- R5: With `fifo_en`=0, raw bit 1 is 1 exactly when `tx_count` is 0, and raw bit 0 is 1 exactly when `rx_count` is not 0. The level selects are ignored.
- R6: A clear of bit 0, 1 or 7 while its condition holds drives the bit to 0. The bit stays 0 until the condition has gone false and then true again.
- R7: With mask bit 2 set and `rx_count` nonzero, the 32nd `bit_tick` without an intervening `rx_push`, `rx_pop` or clear of bit 2 sets raw bit 2. Each of those events restarts the count.
- R8: Raw bit 2 is never 1 while mask bit 2 is 0. It drops to 0 when `rx_count` becomes 0 or when bit 2 is cleared.
- R9: A pulse on `err_frame`, `err_parity`, `err_break` or `err_overrun` sets raw bit 3, 4, 5 or 6 and holds it until that bit is cleared. A set and a clear in the same cycle leave the bit at 1.
- R10: Raw bit 7 is 1 while `tx_count` is 0 and `tx_busy` is 0, subject to the clear rule of R6.
- R11: Bits whose position in `clr_bits` is 0 during a clear write keep their value.
- R12: While `rst` is 1, `raw_stat`, `mask_stat` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 selects FIFO mode, 0 selects single-register mode |
| rx_lvl_sel | input | 3 | Receive level select code |
| tx_lvl_sel | input | 3 | Transmit level select code |
| rx_count | input | CW | Receive FIFO occupancy |
| tx_count | input | CW | Transmit FIFO occupancy |
| tx_busy | input | 1 | Transmit shifter is sending a character |
| rx_push | input | 1 | A character entered the receive FIFO this cycle |
| rx_pop | input | 1 | A character was read from the receive FIFO this cycle |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| err_frame | input | 1 | Framing error pulse |
| err_parity | input | 1 | Parity error pulse |
| err_break | input | 1 | Break pulse |
| err_overrun | input | 1 | Overrun pulse |
| irq_mask | input | 8 | Interrupt mask, one bit per source |
| clr_we | input | 1 | Write strobe for the clear bits |
| clr_bits | input | 8 | Write-one-to-clear bits, one per source |
| raw_stat | output | 8 | Raw status vector |
| mask_stat | output | 8 | Masked status vector |
| irq | output | 1 | Combined interrupt line |

## Verification
A latched error event and a software clear of that same bit can fall in one cycle. The clear must not erase an event that arrives together with it. The bench raises an overrun pulse in the very cycle a clear write targets bit 6, and expects bit 6 to read 1 afterwards. It also expects the break bit cleared in a later cycle to read 0 while the overrun bit stays set. A second collision pairs a clear with a level source whose condition still holds, and the bench expects the source to stay low until its condition toggles.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC   = 8;
  localparam int IX_RX  = 0;
  localparam int IX_TX  = 1;
  localparam int IX_TO  = 2;
  localparam int IX_FRM = 3;
  localparam int IX_PAR = 4;
  localparam int IX_BRK = 5;
  localparam int IX_OVR = 6;
  localparam int IX_EOT = 7;
  localparam int NERR   = 4;
  localparam int NLVL   = 3;

  typedef enum logic [2:0] {
    LVL_QUARTER = 3'd1,
    LVL_HALF    = 3'd2,
    LVL_THREEQ  = 3'd3
  } lvl_code_e;
endpackage

// File: rtl/uart_irq_thresh.sv
module uart_irq_thresh #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          fifo_en,
  input  logic [2:0]    rx_sel,
  input  logic [2:0]    tx_sel,
  input  logic [CW-1:0] rx_cnt,
  input  logic [CW-1:0] tx_cnt,
  input  logic          tx_busy,
  output logic          rx_cond,
  output logic          tx_cond,
  output logic          eot_cond
);
  import uart_irq_pkg::*;

  localparam int QTR  = DEPTH / 4;
  localparam int HALF = DEPTH / 2;
  localparam int TQ   = 3 * (DEPTH / 4);

  // R2: fraction decode, unknown codes fall back to half
  function automatic logic [CW-1:0] level_of(input logic [2:0] code);
    case (code)
      LVL_QUARTER: level_of = CW'(QTR);
      LVL_THREEQ:  level_of = CW'(TQ);
      default:     level_of = CW'(HALF);
    endcase
  endfunction

  logic [CW-1:0] rx_lvl, tx_lvl;

  always_comb begin
    rx_lvl = level_of(rx_sel);
    tx_lvl = level_of(tx_sel);
    if (fifo_en) begin
      // R3, R4
      tx_cond = (tx_cnt <= tx_lvl);
      rx_cond = (rx_cnt >= rx_lvl);
    end else begin
      // R5
      tx_cond = (tx_cnt == '0);
      rx_cond = (rx_cnt != '0);
    end
    // R10
    eot_cond = (tx_cnt == '0) && !tx_busy;
  end
endmodule

// File: rtl/uart_irq_level.sv
module uart_irq_level (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  input  logic clr,
  output logic raw_d,
  output logic raw_q
);
  logic blk_q, blk_d;

  always_comb begin
    blk_d = cond && (blk_q || clr);
    raw_d = cond && !blk_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q <= 1'b0;
      raw_q <= 1'b0;
    end else begin
      blk_q <= blk_d;
      raw_q <= raw_d;
    end
  end

  // R6
  clr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && cond) |=> !raw_q);
  // R6
  cond_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cond |=> !raw_q);
endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic raw_d,
  output logic raw_q
);
  always_comb raw_d = set || (raw_q && !clr);

  always_ff @(posedge clk) begin
    if (rst) raw_q <= 1'b0;
    else     raw_q <= raw_d;
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set |=> raw_q);
  // R9
  clr_only_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !raw_q);
  // R11
  keep_chk: assert property (@(posedge clk) disable iff (rst)
    (raw_q && !clr) |=> raw_q);
endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
  parameter int TO_BITS = 32,
  parameter int TW      = $clog2(TO_BITS)
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic nonempty,
  input  logic tick,
  input  logic restart,
  input  logic clr,
  output logic raw_d,
  output logic raw_q
);
  localparam logic [TW-1:0] LAST = TW'(TO_BITS - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          idle_all, hit;

  always_comb begin
    // R7: any activity, empty FIFO, masked source or clear restarts the count
    idle_all = restart || !nonempty || !enable || clr;
    hit      = tick && !idle_all && (cnt_q == LAST);
    if (idle_all)  cnt_d = '0;
    else if (hit)  cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
    // R8: gated by its own mask
    raw_d = enable && nonempty && !clr && (raw_q || hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      raw_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      raw_q <= raw_d;
    end
  end

  // R8
  to_mask_chk: assert property (@(posedge clk) disable iff (rst)
    raw_q |-> $past(enable));
  // R8
  to_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !nonempty |=> !raw_q);
  // R7
  to_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (restart && !raw_q) |=> !raw_q);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int DEPTH   = 16,
  parameter int TO_BITS = 32,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int NS     = uart_irq_pkg::NSRC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic [2:0]    rx_lvl_sel,
  input  logic [2:0]    tx_lvl_sel,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          tx_busy,
  input  logic          rx_push,
  input  logic          rx_pop,
  input  logic          bit_tick,
  input  logic          err_frame,
  input  logic          err_parity,
  input  logic          err_break,
  input  logic          err_overrun,
  input  logic [NS-1:0] irq_mask,
  input  logic          clr_we,
  input  logic [NS-1:0] clr_bits,
  output logic [NS-1:0] raw_stat,
  output logic [NS-1:0] mask_stat,
  output logic          irq
);
  import uart_irq_pkg::*;

  localparam int LVL_IX [NLVL] = '{IX_RX, IX_TX, IX_EOT};

  logic [NS-1:0]   clr_hit;
  logic [NS-1:0]   raw_d, raw_q;
  logic [NLVL-1:0] lvl_cond;
  logic [NERR-1:0] err_vec;
  logic            rx_cond, tx_cond, eot_cond;
  logic [NS-1:0]   msk_q;
  logic            irq_q;

  // R11: only bits written as 1 clear
  assign clr_hit = clr_we ? clr_bits : '0;
  assign err_vec = {err_overrun, err_break, err_parity, err_frame};

  uart_irq_thresh #(.DEPTH(DEPTH), .CW(CW)) u_thresh (
    .fifo_en (fifo_en),
    .rx_sel  (rx_lvl_sel),
    .tx_sel  (tx_lvl_sel),
    .rx_cnt  (rx_count),
    .tx_cnt  (tx_count),
    .tx_busy (tx_busy),
    .rx_cond (rx_cond),
    .tx_cond (tx_cond),
    .eot_cond(eot_cond)
  );

  assign lvl_cond = {eot_cond, tx_cond, rx_cond};

  genvar gl;
  generate
    for (gl = 0; gl < NLVL; gl++) begin : g_lvl
      uart_irq_level u_lvl (
        .clk  (clk),
        .rst  (rst),
        .cond (lvl_cond[gl]),
        .clr  (clr_hit[LVL_IX[gl]]),
        .raw_d(raw_d[LVL_IX[gl]]),
        .raw_q(raw_q[LVL_IX[gl]])
      );
    end
  endgenerate

  genvar ge;
  generate
    for (ge = 0; ge < NERR; ge++) begin : g_err
      uart_irq_sticky u_err (
        .clk  (clk),
        .rst  (rst),
        .set  (err_vec[ge]),
        .clr  (clr_hit[IX_FRM + ge]),
        .raw_d(raw_d[IX_FRM + ge]),
        .raw_q(raw_q[IX_FRM + ge])
      );
    end
  endgenerate

  uart_irq_timeout #(.TO_BITS(TO_BITS)) u_to (
    .clk     (clk),
    .rst     (rst),
    .enable  (irq_mask[IX_TO]),
    .nonempty(rx_count != '0),
    .tick    (bit_tick),
    .restart (rx_push || rx_pop),
    .clr     (clr_hit[IX_TO]),
    .raw_d   (raw_d[IX_TO]),
    .raw_q   (raw_q[IX_TO])
  );

  // R1: masked view and combined line registered alongside the raw bits
  always_ff @(posedge clk) begin
    if (rst) begin
      msk_q <= '0;
      irq_q <= 1'b0;
    end else begin
      msk_q <= raw_d & irq_mask;
      irq_q <= |(raw_d & irq_mask);
    end
  end

  assign raw_stat  = raw_q;
  assign mask_stat = msk_q;
  assign irq       = irq_q;

  // R1
  msk_and_chk: assert property (@(posedge clk) disable iff (rst)
    mask_stat == (raw_stat & $past(irq_mask)));
  // R1
  irq_or_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (mask_stat != '0));
  // R12
  rst_zero_chk: assert property (@(posedge clk)
    $past(rst) |-> (raw_stat == '0 && mask_stat == '0 && !irq));
endmodule

// File: tb/test_uart_irq_ctrl.sv
`timescale 1ns/1ps
module test_uart_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b1;
  logic [2:0] rx_lvl_sel = 3'd2, tx_lvl_sel = 3'd2;
  logic [4:0] rx_count = '0, tx_count = '0;
  logic       tx_busy = 1'b1, rx_push = 1'b0, rx_pop = 1'b0, bit_tick = 1'b0;
  logic       err_frame = 1'b0, err_parity = 1'b0, err_break = 1'b0, err_overrun = 1'b0;
  logic [7:0] irq_mask = 8'hFF;
  logic       clr_we = 1'b0;
  logic [7:0] clr_bits = '0;
  logic [7:0] raw_stat, mask_stat;
  logic       irq;
  int         total = 0, bad = 0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl #(.DEPTH(16), .TO_BITS(32)) i_uart_irq_ctrl (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_lvl_sel(rx_lvl_sel),
    .tx_lvl_sel(tx_lvl_sel), .rx_count(rx_count), .tx_count(tx_count),
    .tx_busy(tx_busy), .rx_push(rx_push), .rx_pop(rx_pop), .bit_tick(bit_tick),
    .err_frame(err_frame), .err_parity(err_parity), .err_break(err_break),
    .err_overrun(err_overrun), .irq_mask(irq_mask), .clr_we(clr_we),
    .clr_bits(clr_bits), .raw_stat(raw_stat), .mask_stat(mask_stat), .irq(irq)
  );

  typedef struct packed {
    logic       fe;
    logic [2:0] rs;
    logic [2:0] ts;
    logic [4:0] rc;
    logic [4:0] tc;
    logic       erx;
    logic       etx;
  } vec_t;

  // depth 16: quarter 4, half 8, three quarters 12
  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'd1, 3'd1, 5'd4,  5'd4,  1'b1, 1'b1},
    '{1'b1, 3'd1, 3'd1, 5'd3,  5'd5,  1'b0, 1'b0},
    '{1'b1, 3'd2, 3'd2, 5'd8,  5'd8,  1'b1, 1'b1},
    '{1'b1, 3'd2, 3'd2, 5'd7,  5'd9,  1'b0, 1'b0},
    '{1'b1, 3'd3, 3'd3, 5'd12, 5'd12, 1'b1, 1'b1},
    '{1'b1, 3'd3, 3'd3, 5'd11, 5'd13, 1'b0, 1'b0},
    '{1'b1, 3'd0, 3'd7, 5'd8,  5'd8,  1'b1, 1'b1},
    '{1'b1, 3'd5, 3'd4, 5'd7,  5'd9,  1'b0, 1'b0},
    '{1'b1, 3'd3, 3'd1, 5'd16, 5'd0,  1'b1, 1'b1},
    '{1'b0, 3'd3, 3'd3, 5'd1,  5'd0,  1'b1, 1'b1},
    '{1'b0, 3'd3, 3'd3, 5'd0,  5'd1,  1'b0, 1'b0},
    '{1'b0, 3'd1, 3'd1, 5'd1,  5'd1,  1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      bit_tick = 1'b1; cyc();
      bit_tick = 1'b0; cyc();
    end
  endtask

  task automatic clear(input logic [7:0] b);
    clr_we = 1'b1; clr_bits = b; cyc();
    clr_we = 1'b0; clr_bits = '0;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog all-reqs act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R12: reset holds everything low even with conditions true
    err_frame = 1'b1;
    repeat (3) cyc();
    check("R12 raw", raw_stat, 0);
    check("R12 masked", mask_stat, 0);
    check("R12 irq", irq, 0);
    err_frame = 1'b0;
    rst = 1'b0;
    cyc();

    // R1-R5 table, timeout masked off, shifter busy so bit 7 stays 0
    for (int i = 0; i < NV; i++) begin
      fifo_en = TBL[i].fe; rx_lvl_sel = TBL[i].rs; tx_lvl_sel = TBL[i].ts;
      rx_count = TBL[i].rc; tx_count = TBL[i].tc;
      irq_mask = (i % 2 == 0) ? 8'h03 : 8'h01;
      cyc();
      check("R2/R3/R4/R5 raw", raw_stat, {6'd0, TBL[i].etx, TBL[i].erx});
      check("R1 masked", mask_stat, raw_stat & irq_mask);
      check("R1 irq", irq, |(raw_stat & irq_mask));
    end

    // R6: clear while transmit condition holds
    irq_mask = 8'h00;
    fifo_en = 1'b1; rx_lvl_sel = 3'd2; tx_lvl_sel = 3'd2;
    rx_count = 5'd0; tx_count = 5'd0;
    cyc();
    check("R3 tx empty", raw_stat[1], 1);
    clear(8'h02);
    check("R6 cleared", raw_stat[1], 0);
    cyc();
    check("R6 stays cleared", raw_stat[1], 0);
    tx_count = 5'd10; cyc();
    check("R6 cond false", raw_stat[1], 0);
    tx_count = 5'd2; cyc();
    check("R6 re-armed", raw_stat[1], 1);

    // R9 / R11: sticky errors and set-clear collision
    err_frame = 1'b1; cyc(); err_frame = 1'b0;
    check("R9 frame set", raw_stat[3], 1);
    clear(8'h00);
    check("R11 zero clear", raw_stat[3], 1);
    clear(8'h08);
    check("R9 frame cleared", raw_stat[3], 0);
    err_break = 1'b1; cyc(); err_break = 1'b0;
    check("R9 break set", raw_stat[5], 1);
    err_overrun = 1'b1; clr_we = 1'b1; clr_bits = 8'h40; cyc();
    err_overrun = 1'b0; clr_we = 1'b0; clr_bits = '0;
    check("R9 set wins", raw_stat[6], 1);
    clear(8'h20);
    check("R9 break cleared", raw_stat[5], 0);
    check("R11 overrun kept", raw_stat[6], 1);
    err_parity = 1'b1; cyc(); err_parity = 1'b0;
    check("R9 parity set", raw_stat[4], 1);
    clear(8'h50);

    // R7 / R8: receive timeout
    rx_lvl_sel = 3'd3; rx_count = 5'd1; irq_mask = 8'h04;
    cyc();
    ticks(31);
    check("R7 31 ticks", raw_stat[2], 0);
    rx_push = 1'b1; cyc(); rx_push = 1'b0;
    ticks(31);
    check("R7 push restart", raw_stat[2], 0);
    ticks(1);
    check("R7 fired", raw_stat[2], 1);
    check("R8 masked same", mask_stat[2], 1);
    check("R1 irq timeout", irq, 1);
    clear(8'h04);
    check("R8 clear", raw_stat[2], 0);
    ticks(20);
    rx_pop = 1'b1; cyc(); rx_pop = 1'b0;
    ticks(31);
    check("R7 pop restart", raw_stat[2], 0);
    ticks(1);
    check("R7 fired again", raw_stat[2], 1);
    rx_count = 5'd0; cyc();
    check("R8 emptied", raw_stat[2], 0);
    rx_count = 5'd1; irq_mask = 8'h00; cyc();
    ticks(40);
    check("R8 gated raw", raw_stat[2], 0);
    check("R8 gated masked", mask_stat[2], 0);

    // R10: end of transmission
    tx_count = 5'd0; tx_busy = 1'b1; cyc();
    check("R10 busy", raw_stat[7], 0);
    tx_busy = 1'b0; cyc();
    check("R10 idle", raw_stat[7], 1);
    clear(8'h80);
    check("R10 cleared", raw_stat[7], 0);
    tx_busy = 1'b1; cyc();
    tx_busy = 1'b0; cyc();
    check("R10 re-armed", raw_stat[7], 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule